// File: doc/BRIEF.md
# Debug Instruction Transfer Scan Chain

This block is a 33-cell data-register scan chain clocked by TCK. A debugger uses it to place a 32-bit instruction word in a holding register and then hand that word to a processor core. One extra cell carries a completion flag that the debugger can read but never write. The TAP controller supplies one-cycle-per-state strobes for Capture-DR, Shift-DR, Update-DR and Run-Test/Idle, together with the selected chain number and the active TAP instruction code. The core supplies its debug-state indication, the execute-enable control bit, the sticky data-abort flag and a pulse when an issued instruction finishes.

Loading and issuing are gated by two separate sets of conditions. Both sets require a ready bit, which is the completion flag latched at the most recent Capture-DR. The serial path (TDI in, TDO out) has no handshake. The TAP state sequence paces every bit, and there is no back-pressure: a strobe that meets its conditions acts in the cycle it is sampled.

Top module: `dbg_itr_chain`

## Requirements
- R1: After reset the held instruction is 0, the issue strobe is 0, the completion flag is 1 and the ready bit is 0.
- R2: On a Capture-DR cycle with chain 4 selected, cells 32..1 load the held instruction and cell 0 loads the completion flag. On every Capture-DR cycle, whatever chain is selected, the ready bit latches the completion flag.
- R3: On a Shift-DR cycle with chain 4 selected, TDO shows cell 0 and the chain shifts one place toward cell 0, with TDI entering cell 32. At all other times TDO is 0.
- R4: The bit shifted into cell 0 is discarded. It never alters the completion flag, and a later capture reads back the real flag.
- R5: The completion flag clears when an instruction is issued and sets on the core's completion pulse. If the two happen in the same cycle, the issue wins and the flag is cleared.
- R6: On Update-DR, cells 32..1 are written to the held instruction only when chain 4 is selected, the TAP instruction is EXTEST (code 4'h0) and the ready bit is 1.
- R7: Loading ignores debug state, execute-enable and the sticky abort flag.
- R8: An issue happens only when all of the following hold: the core is in debug state, execute-enable is 1, chain 4 or chain 5 is selected, the instruction is INTEST (4'hC) or EXTEST (4'h0), the ready bit is 1, and the abort flag is 0.
- R9: The issue strobe is high for exactly one cycle, in the cycle after the first cycle of a Run-Test/Idle visit. Staying in Run-Test/Idle does not repeat it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock (TCK) |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| run_idle_i | input | 1 | TAP is in Run-Test/Idle |
| tdi_i | input | 1 | Serial data in |
| chain_sel_i | input | 5 | Selected scan chain number |
| ir_code_i | input | 4 | Active TAP instruction code |
| dbg_state_i | input | 1 | Core is in debug state |
| exec_en_i | input | 1 | Instruction execution from the debugger is enabled |
| abort_sticky_i | input | 1 | Sticky precise data-abort flag |
| insn_done_i | input | 1 | Core completed the issued instruction (pulse) |
| tdo_o | output | 1 | Serial data out |
| insn_o | output | 32 | Held instruction word |
| issue_o | output | 1 | One-cycle instruction issue strobe |

## Verification
TDO is combinational from cell 0, so the bench samples it one time unit after it drives each shift bit, before the rising edge. The held word, the completion flag and the ready bit all register on the strobe's edge. The issue strobe rises on the edge that ends the first Run-Test/Idle cycle. Every stimulus is applied just after a falling edge, and the dependent result is read at the next falling edge, which is one register stage later. The strobe is also read a second time one cycle after that, to confirm it has dropped. The completion flag is observed only at the ports: the bench runs a capture and shifts the chain out.

// File: rtl/dbg_itr_pkg.sv
package dbg_itr_pkg;
  localparam int unsigned CHAIN_W = 5;
  localparam int unsigned IR_W    = 4;

  typedef logic [IR_W-1:0]    ir_code_t;
  typedef logic [CHAIN_W-1:0] chain_t;

  localparam ir_code_t IR_EXTEST = 4'h0;
  localparam ir_code_t IR_INTEST = 4'hC;

  localparam chain_t CHAIN_ITR = 5'd4;
  localparam chain_t CHAIN_ALT = 5'd5;
endpackage

// File: rtl/itr_shift_chain.sv
module itr_shift_chain #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              tdi,
  input  logic [DATA_W-1:0] held_word,
  input  logic              flag,
  output logic [DATA_W-1:0] word_o,
  output logic              lsb_o
);
  localparam int unsigned LEN = DATA_W + 1;

  logic [LEN-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (capture_en) begin
      sr <= {held_word, flag};
    end else if (shift_en) begin
      sr <= {tdi, sr[LEN-1:1]};
    end
  end

  assign word_o = sr[LEN-1:1];
  assign lsb_o  = sr[0];
endmodule

// File: rtl/itr_gate.sv
module itr_gate
  import dbg_itr_pkg::*;
(
  input  chain_t   chain_sel,
  input  ir_code_t ir_code,
  input  logic     dbg_state,
  input  logic     exec_en,
  input  logic     abort_sticky,
  input  logic     ready,
  input  logic     update,
  input  logic     rti_entry,
  output logic     load_go,
  output logic     issue_go
);
  logic chain_ok_load, chain_ok_issue, ir_ok_issue;

  always_comb begin
    chain_ok_load  = (chain_sel == CHAIN_ITR);
    chain_ok_issue = (chain_sel == CHAIN_ITR) || (chain_sel == CHAIN_ALT);
    ir_ok_issue    = (ir_code == IR_EXTEST) || (ir_code == IR_INTEST);
    load_go  = update && chain_ok_load && (ir_code == IR_EXTEST) && ready;
    issue_go = rti_entry && dbg_state && exec_en && chain_ok_issue &&
               ir_ok_issue && ready && !abort_sticky;
  end
endmodule

// File: rtl/itr_cmpl_flag.sv
module itr_cmpl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_go,
  input  logic done,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b1;
    else if (issue_go) flag <= 1'b0;
    else if (done)     flag <= 1'b1;
  end
endmodule

// File: rtl/dbg_itr_chain.sv
module dbg_itr_chain
  import dbg_itr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              run_idle_i,
  input  logic              tdi_i,
  input  logic [4:0]        chain_sel_i,
  input  logic [3:0]        ir_code_i,
  input  logic              dbg_state_i,
  input  logic              exec_en_i,
  input  logic              abort_sticky_i,
  input  logic              insn_done_i,
  output logic              tdo_o,
  output logic [DATA_W-1:0] insn_o,
  output logic              issue_o
);
  logic              chain_hit;
  logic              rti_q;
  logic              rti_entry;
  logic              ready_q;
  logic              cmpl_flag;
  logic              load_go;
  logic              issue_go;
  logic [DATA_W-1:0] sr_word;
  logic              sr_lsb;

  assign chain_hit = (chain_sel_i == CHAIN_ITR);
  assign rti_entry = run_idle_i && !rti_q;

  itr_shift_chain #(.DATA_W(DATA_W)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_dr_i && chain_hit),
    .shift_en   (shift_dr_i && chain_hit),
    .tdi        (tdi_i),
    .held_word  (insn_o),
    .flag       (cmpl_flag),
    .word_o     (sr_word),
    .lsb_o      (sr_lsb)
  );

  itr_gate u_gate (
    .chain_sel    (chain_sel_i),
    .ir_code      (ir_code_i),
    .dbg_state    (dbg_state_i),
    .exec_en      (exec_en_i),
    .abort_sticky (abort_sticky_i),
    .ready        (ready_q),
    .update       (update_dr_i),
    .rti_entry    (rti_entry),
    .load_go      (load_go),
    .issue_go     (issue_go)
  );

  itr_cmpl_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_go (issue_go),
    .done     (insn_done_i),
    .flag     (cmpl_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rti_q   <= 1'b0;
      ready_q <= 1'b0;
      insn_o  <= '0;
      issue_o <= 1'b0;
    end else begin
      rti_q   <= run_idle_i;
      issue_o <= issue_go;
      if (capture_dr_i) ready_q <= cmpl_flag;
      if (load_go)      insn_o  <= sr_word;
    end
  end

  assign tdo_o = (shift_dr_i && chain_hit) ? sr_lsb : 1'b0;
endmodule

// File: rtl/dbg_itr_chain_chk.sv
module dbg_itr_chain_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_dr_i,
  input logic              update_dr_i,
  input logic [4:0]        chain_sel_i,
  input logic [3:0]        ir_code_i,
  input logic              insn_done_i,
  input logic              tdo_o,
  input logic [DATA_W-1:0] insn_o,
  input logic              issue_o,
  input logic              cmpl_flag,
  input logic              ready_q,
  input logic              issue_go
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> !issue_o);

  a_r8_issue_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    issue_go |-> ready_q);

  a_r5_issue_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> !cmpl_flag);

  a_r5_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done_i && !issue_go) |=> cmpl_flag);

  a_r6_load_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(insn_o) |-> $past(update_dr_i && chain_sel_i == 5'd4 &&
                               ir_code_i == 4'h0 && ready_q));

  a_r3_tdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_dr_i && chain_sel_i == 5'd4) |-> !tdo_o);
endmodule

bind dbg_itr_chain dbg_itr_chain_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shift_dr_i  (shift_dr_i),
  .update_dr_i (update_dr_i),
  .chain_sel_i (chain_sel_i),
  .ir_code_i   (ir_code_i),
  .insn_done_i (insn_done_i),
  .tdo_o       (tdo_o),
  .insn_o      (insn_o),
  .issue_o     (issue_o),
  .cmpl_flag   (cmpl_flag),
  .ready_q     (ready_q),
  .issue_go    (issue_go)
);

// File: tb/tb_dbg_itr_chain.sv
`timescale 1ns/1ps
module tb_dbg_itr_chain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        capture_dr_i = 0, shift_dr_i = 0, update_dr_i = 0, run_idle_i = 0;
  logic        tdi_i = 0;
  logic [4:0]  chain_sel_i = 5'd4;
  logic [3:0]  ir_code_i = 4'h0;
  logic        dbg_state_i = 0, exec_en_i = 0, abort_sticky_i = 0, insn_done_i = 0;
  logic        tdo_o;
  logic [31:0] insn_o;
  logic        issue_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  dbg_itr_chain dut (.*);

  // vector: chain[12:8] ir[7:4] dbg[3] exec[2] abort[1] expect_issue[0]
  localparam logic [12:0] VEC [9] = '{
    {5'd4, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd5, 4'hC, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd4, 4'hC, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd5, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd6, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0},
    {5'd4, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd4, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd4, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0},
    {5'd4, 4'h5, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_capture();
    capture_dr_i = 1; cyc(); capture_dr_i = 0;
  endtask

  task automatic do_shift(input logic [32:0] din, output logic [32:0] dout);
    shift_dr_i = 1;
    for (int i = 0; i < 33; i++) begin
      tdi_i = din[i];
      #1 dout[i] = tdo_o;
      cyc();
    end
    shift_dr_i = 0;
  endtask

  task automatic do_update();
    update_dr_i = 1; cyc(); update_dr_i = 0;
  endtask

  task automatic read_chain(output logic [31:0] w, output logic f);
    logic [32:0] d;
    logic [4:0] c;
    c = chain_sel_i; chain_sel_i = 5'd4;
    do_capture();
    do_shift(33'h0, d);
    w = d[32:1]; f = d[0];
    chain_sel_i = c;
  endtask

  task automatic load_word(input logic [31:0] w, input logic b0);
    logic [32:0] d;
    do_capture();
    do_shift({w, b0}, d);
    do_update();
  endtask

  task automatic pulse_done();
    insn_done_i = 1; cyc(); insn_done_i = 0;
  endtask

  initial begin
    #100000;
    if (!done_run) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic f;
    logic [32:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 insn", insn_o, 32'h0);
    check("R1 issue", {31'h0, issue_o}, 32'h0);
    check("R3 tdo idle", {31'h0, tdo_o}, 32'h0);
    // R8 ready bit starts 0: issue attempt before any capture
    dbg_state_i = 1; exec_en_i = 1;
    run_idle_i = 1; cyc();
    check("R1 R8 no issue without ready", {31'h0, issue_o}, 32'h0);
    run_idle_i = 0; cyc();
    read_chain(w, f);
    check("R1 R2 flag after reset", {31'h0, f}, 32'h1);
    check("R2 word after reset", w, 32'h0);

    // R6 R7 load with debug state off, exec off, abort set
    dbg_state_i = 0; exec_en_i = 0; abort_sticky_i = 1;
    load_word(32'hE1A0_1002, 1'b0);
    check("R6 R7 load", insn_o, 32'hE1A0_1002);
    // R2 R4 readback, cell 0 shifted as 0 ignored
    read_chain(w, f);
    check("R2 readback word", w, 32'hE1A0_1002);
    check("R4 flag not written", {31'h0, f}, 32'h1);

    // R6 rejected with INTEST
    ir_code_i = 4'hC;
    load_word(32'h1234_5678, 1'b1);
    check("R6 INTEST no load", insn_o, 32'hE1A0_1002);
    // R6 rejected with chain 5 (shift into chain 5 also keeps tdo 0)
    ir_code_i = 4'h0; chain_sel_i = 5'd5;
    do_capture();
    shift_dr_i = 1; tdi_i = 1; #1;
    check("R3 tdo other chain", {31'h0, tdo_o}, 32'h0);
    cyc(); shift_dr_i = 0;
    do_update();
    check("R6 chain5 no load", insn_o, 32'hE1A0_1002);
    chain_sel_i = 5'd4; abort_sticky_i = 0;

    // R8 R9 vector table
    for (int k = 0; k < 9; k++) begin
      chain_sel_i = VEC[k][12:8]; ir_code_i = VEC[k][7:4];
      dbg_state_i = VEC[k][3]; exec_en_i = VEC[k][2]; abort_sticky_i = VEC[k][1];
      do_capture();
      run_idle_i = 1; cyc();
      check($sformatf("R8 vec%0d issue", k), {31'h0, issue_o}, {31'h0, VEC[k][0]});
      cyc();
      check($sformatf("R9 vec%0d one pulse", k), {31'h0, issue_o}, 32'h0);
      run_idle_i = 0; cyc();
      pulse_done();
    end

    // R5 issue clears flag; ready then 0 blocks load and issue
    chain_sel_i = 5'd4; ir_code_i = 4'h0; dbg_state_i = 1; exec_en_i = 1; abort_sticky_i = 0;
    do_capture();
    run_idle_i = 1; cyc(); run_idle_i = 0; cyc();
    read_chain(w, f);
    check("R5 flag cleared by issue", {31'h0, f}, 32'h0);
    load_word(32'hDEAD_BEEF, 1'b1);
    check("R6 no load when not ready", insn_o, 32'hE1A0_1002);
    run_idle_i = 1; cyc();
    check("R8 no issue when not ready", {31'h0, issue_o}, 32'h0);
    run_idle_i = 0; cyc();
    pulse_done();
    read_chain(w, f);
    check("R5 flag set by done", {31'h0, f}, 32'h1);

    // R5 issue and completion in the same cycle: issue wins
    run_idle_i = 1; insn_done_i = 1; cyc();
    run_idle_i = 0; insn_done_i = 0;
    check("R9 issue strobe", {31'h0, issue_o}, 32'h1);
    cyc();
    read_chain(w, f);
    check("R5 issue beats done", {31'h0, f}, 32'h0);
    pulse_done();

    // R3 shifted bits emerge on tdo in order
    read_chain(w, f);
    do_capture();
    do_shift({32'hA5A5_0F0F, 1'b0}, d);
    check("R3 shift out flag", {31'h0, d[0]}, 32'h1);
    check("R3 shift out word", d[32:1], 32'hE1A0_1002);

    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule